// File: doc/BRIEF.md
# Byte-Command I2C Master Engine

This block is an I2C bus master controlled one command byte at a time. A host feeds it single bytes over a valid/ready input stream. Each byte either performs one bus primitive or changes a setting. These primitives are a start condition, a stop condition, reading one byte, driving one acknowledge bit, and writing a burst of data bytes. The settings are the SCL rate and four peripheral control pins. Every command answers with one or more bytes on a valid/ready output stream. The host therefore builds any transaction itself and sees the outcome of each step.

The bus pins are open-drain. The block only asserts an active-high "pull low" enable for SCL and for SDA, and reads SDA back. Each bit is divided into four equal quarter periods. The quarter length for each of the four speed codes is derived from the system clock frequency parameter. Reading a byte never clocks an acknowledge bit on its own; the host must follow it with an ACK or NACK command. A zero command byte leaves the mode, which the block signals with a one-cycle strobe.

Top module: `i2c_cmd_engine`

## Requirements
- R1: Command 0x02 produces a start condition (SDA falls while SCL is released) and replies 0x01.
- R2: Command 0x03 produces a stop condition (SDA rises while SCL is released) and replies 0x01.
- R3: Command 0x04 clocks exactly eight bits from SDA, most significant first, and replies with that byte. No ninth clock is generated.
- R4: Commands 0x06 and 0x07 each produce one SCL pulse. SDA is held low for 0x06 and released for 0x07. Each replies 0x01.
- R5: Command 0x01 replies with the four bytes 0x49, 0x32, 0x43, 0x31 in that order.
- R6: Command 0x10+n (n in 0..15) replies 0x01 and then takes n+1 data bytes. Each data byte is sent most significant bit first, followed by a ninth clock. After each byte the block replies 0x00 if SDA was low on that ninth clock and 0x01 if it was high.
- R7: Bytes accepted while a bulk write is outstanding are sent as data and never decoded as commands.
- R8: Command 0x4X latches X onto the pins: bit 3 to the power enable, bit 2 to the pull-up enable, bit 1 to the auxiliary level, bit 0 to the chip-select level. It replies 0x01. All four pins are 0 after reset.
- R9: Command 0x60+c (c in 0..3) selects the SCL rate: 0 gives 5 kHz, 1 gives 50 kHz, 2 gives 100 kHz and 3 gives 400 kHz. SCL stays released for 2·Q system clocks per bit, where Q = CLK_HZ/(4·rate). The command replies 0x01. Code 3 is active after reset.
- R10: Any other command byte replies 0x00 and causes no SCL or SDA activity.
- R11: Command 0x00 raises `exit_pulse` for exactly one cycle and produces no reply.
- R12: A reply stays valid with unchanged data until `rsp_ready` is seen. `cmd_ready` is low while a reply is pending or a bus operation is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Host command/data byte valid |
| cmd_ready | output | 1 | Engine accepts a byte this cycle |
| cmd_data | input | 8 | Host command or bulk data byte |
| rsp_valid | output | 1 | Reply byte valid |
| rsp_ready | input | 1 | Host takes the reply byte |
| rsp_data | output | 8 | Reply byte |
| exit_pulse | output | 1 | One-cycle strobe on the leave-mode command |
| sda_in | input | 1 | Sensed SDA line level |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| pwr_en | output | 1 | Peripheral power enable |
| pullup_en | output | 1 | Bus pull-up enable |
| aux_level | output | 1 | Auxiliary output level |
| cs_level | output | 1 | Chip-select output level |

## Verification
The bench builds the engine with CLK_HZ set to 4 MHz. This gives quarter periods of 200, 20, 10 and 2 clocks for the four speed codes. The SCL high time can then be checked exactly for every code, the 5 kHz one included, within a short run. At this setting the default 400 kHz rate gives a 4-clock high phase, so start, bulk and read sequences finish in a few hundred cycles. The fastest setting also exercises the one-quarter-per-two-clocks corner of the bit sequencer.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;

   typedef enum logic [1:0] {PH_START, PH_STOP, PH_BITS} phy_op_e;

   localparam logic [7:0] CMD_LEAVE   = 8'h00;
   localparam logic [7:0] CMD_IDENT   = 8'h01;
   localparam logic [7:0] CMD_START   = 8'h02;
   localparam logic [7:0] CMD_STOP    = 8'h03;
   localparam logic [7:0] CMD_READ    = 8'h04;
   localparam logic [7:0] CMD_ACK     = 8'h06;
   localparam logic [7:0] CMD_NACK    = 8'h07;

   function automatic int unsigned scl_rate_hz(input int unsigned code);
      case (code)
         0:       return 5000;
         1:       return 50000;
         2:       return 100000;
         default: return 400000;
      endcase
   endfunction

   function automatic logic [7:0] ident_char(input logic [1:0] idx);
      case (idx)
         2'd0:    return 8'h49;
         2'd1:    return 8'h32;
         2'd2:    return 8'h43;
         default: return 8'h31;
      endcase
   endfunction

endpackage

// File: rtl/i2c_rate_table.sv
module i2c_rate_table
   import i2c_cmd_pkg::*;
#(
   parameter int unsigned CLK_HZ = 50_000_000,
   parameter int unsigned QW     = 12
) (
   input  logic [1:0]    code,
   output logic [QW-1:0] qlen
);

   logic [QW-1:0] tbl [4];

   for (genvar k = 0; k < 4; k++) begin : g_rate
      localparam int unsigned RAW = CLK_HZ / (4 * scl_rate_hz(k));
      localparam int unsigned LEN = (RAW == 0) ? 1 : RAW;
      assign tbl[k] = QW'(LEN);
   end

   assign qlen = tbl[code];

endmodule

// File: rtl/i2c_bit_phy.sv
module i2c_bit_phy
   import i2c_cmd_pkg::*;
#(
   parameter int unsigned QW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  phy_op_e       op,
   input  logic [8:0]    tx,
   input  logic [3:0]    nbits,
   input  logic [QW-1:0] qlen,
   input  logic          sda_in,
   output logic          done,
   output logic [8:0]    rx,
   output logic          scl_low,
   output logic          sda_low
);

   logic          busy;
   phy_op_e       op_q;
   logic [1:0]    qidx;
   logic [QW-1:0] cnt;
   logic [8:0]    sh;
   logic [3:0]    left;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         op_q    <= PH_START;
         qidx    <= '0;
         cnt     <= '0;
         sh      <= '0;
         left    <= '0;
         rx      <= '0;
         done    <= 1'b0;
         scl_low <= 1'b0;
         sda_low <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!busy && go) begin
            busy <= 1'b1;
            op_q <= op;
            sh   <= tx;
            left <= nbits;
            qidx <= '0;
            cnt  <= qlen - 1'b1;
            rx   <= '0;
            case (op)
               PH_START: sda_low <= 1'b0;
               PH_STOP: begin
                  scl_low <= 1'b1;
                  sda_low <= 1'b1;
               end
               default: begin
                  scl_low <= 1'b1;
                  sda_low <= ~tx[8];
               end
            endcase
         end else if (busy) begin
            if (cnt != '0) begin
               cnt <= cnt - 1'b1;
            end else begin
               cnt  <= qlen - 1'b1;
               qidx <= qidx + 1'b1;
               case (qidx)
                  2'd0: if (op_q != PH_BITS) scl_low <= 1'b0;
                  2'd1: begin
                     if (op_q == PH_START)     sda_low <= 1'b1;
                     else if (op_q == PH_STOP) sda_low <= 1'b0;
                     else                      scl_low <= 1'b0;
                  end
                  2'd2: begin
                     if (op_q == PH_START)     scl_low <= 1'b1;
                     else if (op_q == PH_BITS) rx <= {rx[7:0], sda_in};
                  end
                  default: begin
                     if (op_q == PH_BITS) scl_low <= 1'b1;
                     if (op_q == PH_BITS && left > 4'd1) begin
                        left    <= left - 1'b1;
                        sh      <= sh << 1;
                        sda_low <= ~sh[7];
                     end else begin
                        busy <= 1'b0;
                        done <= 1'b1;
                     end
                  end
               endcase
            end
         end
      end
   end

endmodule

// File: rtl/i2c_cmd_engine.sv
module i2c_cmd_engine
   import i2c_cmd_pkg::*;
#(
   parameter int unsigned CLK_HZ      = 50_000_000,
   parameter int unsigned RESET_SPEED = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   output logic       cmd_ready,
   input  logic [7:0] cmd_data,
   output logic       rsp_valid,
   input  logic       rsp_ready,
   output logic [7:0] rsp_data,
   output logic       exit_pulse,
   input  logic       sda_in,
   output logic       scl_drive_low,
   output logic       sda_drive_low,
   output logic       pwr_en,
   output logic       pullup_en,
   output logic       aux_level,
   output logic       cs_level
);

   localparam int unsigned QMAX = CLK_HZ / (4 * scl_rate_hz(0));
   localparam int unsigned QW   = $clog2(QMAX + 1);

   if (CLK_HZ < 4 * 400000) begin : g_bad_clk
      $error("CLK_HZ too low for the fastest SCL rate");
   end
   if (RESET_SPEED > 3) begin : g_bad_speed
      $error("RESET_SPEED must be 0..3");
   end

   typedef enum logic [1:0] {ST_CMD, ST_BULK, ST_BUS, ST_RSP} st_e;
   typedef enum logic [1:0] {RK_ONE, RK_BYTE, RK_ACK} rk_e;

   st_e        st, nxt;
   rk_e        kind;
   logic [1:0] speed, id_idx;
   logic [4:0] bulk_left;
   logic [3:0] pins;
   logic       go_q;
   phy_op_e    op_q;
   logic [8:0] tx_q;
   logic [3:0] nb_q;
   logic [QW-1:0] qlen;
   logic       phy_done;
   logic [8:0] phy_rx;
   logic       accept;

   assign cmd_ready = (st == ST_CMD) || (st == ST_BULK);
   assign accept    = cmd_valid && cmd_ready;
   assign {pwr_en, pullup_en, aux_level, cs_level} = pins;

   i2c_rate_table #(.CLK_HZ(CLK_HZ), .QW(QW)) u_rate (
      .code (speed),
      .qlen (qlen)
   );

   i2c_bit_phy #(.QW(QW)) u_phy (
      .clk     (clk),
      .rst_n   (rst_n),
      .go      (go_q),
      .op      (op_q),
      .tx      (tx_q),
      .nbits   (nb_q),
      .qlen    (qlen),
      .sda_in  (sda_in),
      .done    (phy_done),
      .rx      (phy_rx),
      .scl_low (scl_drive_low),
      .sda_low (sda_drive_low)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st         <= ST_CMD;
         nxt        <= ST_CMD;
         kind       <= RK_ONE;
         speed      <= RESET_SPEED[1:0];
         id_idx     <= '0;
         bulk_left  <= '0;
         pins       <= '0;
         go_q       <= 1'b0;
         op_q       <= PH_START;
         tx_q       <= '0;
         nb_q       <= '0;
         rsp_valid  <= 1'b0;
         rsp_data   <= '0;
         exit_pulse <= 1'b0;
      end else begin
         go_q       <= 1'b0;
         exit_pulse <= 1'b0;
         unique case (st)
            ST_CMD: if (accept) begin
               nxt <= ST_CMD;
               casez (cmd_data)
                  CMD_LEAVE: exit_pulse <= 1'b1;
                  CMD_IDENT: begin
                     rsp_data  <= ident_char(2'd0);
                     rsp_valid <= 1'b1;
                     id_idx    <= 2'd1;
                     st        <= ST_RSP;
                  end
                  CMD_START, CMD_STOP: begin
                     op_q <= (cmd_data == CMD_START) ? PH_START : PH_STOP;
                     kind <= RK_ONE;
                     go_q <= 1'b1;
                     st   <= ST_BUS;
                  end
                  CMD_READ: begin
                     op_q <= PH_BITS;
                     tx_q <= 9'h1FF;
                     nb_q <= 4'd8;
                     kind <= RK_BYTE;
                     go_q <= 1'b1;
                     st   <= ST_BUS;
                  end
                  CMD_ACK, CMD_NACK: begin
                     op_q <= PH_BITS;
                     tx_q <= {cmd_data[0], 8'hFF};
                     nb_q <= 4'd1;
                     kind <= RK_ONE;
                     go_q <= 1'b1;
                     st   <= ST_BUS;
                  end
                  8'b0001_????: begin
                     bulk_left <= {1'b0, cmd_data[3:0]} + 5'd1;
                     rsp_data  <= 8'h01;
                     rsp_valid <= 1'b1;
                     nxt       <= ST_BULK;
                     st        <= ST_RSP;
                  end
                  8'b0100_????: begin
                     pins      <= cmd_data[3:0];
                     rsp_data  <= 8'h01;
                     rsp_valid <= 1'b1;
                     st        <= ST_RSP;
                  end
                  8'b0110_00??: begin
                     speed     <= cmd_data[1:0];
                     rsp_data  <= 8'h01;
                     rsp_valid <= 1'b1;
                     st        <= ST_RSP;
                  end
                  default: begin
                     rsp_data  <= 8'h00;
                     rsp_valid <= 1'b1;
                     st        <= ST_RSP;
                  end
               endcase
            end
            ST_BULK: if (accept) begin
               op_q      <= PH_BITS;
               tx_q      <= {cmd_data, 1'b1};
               nb_q      <= 4'd9;
               kind      <= RK_ACK;
               go_q      <= 1'b1;
               bulk_left <= bulk_left - 5'd1;
               nxt       <= (bulk_left == 5'd1) ? ST_CMD : ST_BULK;
               st        <= ST_BUS;
            end
            ST_BUS: if (phy_done) begin
               rsp_valid <= 1'b1;
               case (kind)
                  RK_BYTE: rsp_data <= phy_rx[7:0];
                  RK_ACK:  rsp_data <= {7'd0, phy_rx[0]};
                  default: rsp_data <= 8'h01;
               endcase
               st <= ST_RSP;
            end
            default: if (rsp_ready) begin
               if (id_idx != 2'd0) begin
                  rsp_data <= ident_char(id_idx);
                  id_idx   <= id_idx + 2'd1;
               end else begin
                  rsp_valid <= 1'b0;
                  st        <= nxt;
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/i2c_cmd_engine_chk.sv
module i2c_cmd_engine_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_valid,
   input logic       cmd_ready,
   input logic [7:0] cmd_data,
   input logic       rsp_valid,
   input logic       rsp_ready,
   input logic [7:0] rsp_data,
   input logic       exit_pulse,
   input logic       pwr_en,
   input logic       pullup_en,
   input logic       aux_level,
   input logic       cs_level
);

   p_rsp_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

   p_one_side_r12: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !cmd_ready);

   p_exit_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
      exit_pulse |-> $past(cmd_valid && cmd_ready && cmd_data == 8'h00));

   p_exit_width_r11: assert property (@(posedge clk) disable iff (!rst_n)
      exit_pulse |=> !exit_pulse);

   p_pin_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({pwr_en, pullup_en, aux_level, cs_level})
      |-> $past(cmd_valid && cmd_ready && cmd_data[7:4] == 4'h4));

endmodule

bind i2c_cmd_engine i2c_cmd_engine_chk u_chk (.*);

// File: tb/sim_i2c_cmd_engine.sv
module sim_i2c_cmd_engine;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [7:0] cmd_data = '0;
   logic       rsp_ready = 1'b0;
   logic       cmd_ready, rsp_valid, exit_pulse;
   logic [7:0] rsp_data;
   logic       scl_drive_low, sda_drive_low;
   logic       pwr_en, pullup_en, aux_level, cs_level;

   int n_cmp = 0;
   int n_bad = 0;

   // bus lines and slave model
   logic scl_line, sda_line, pull;
   logic rd_mode = 1'b0;
   logic ack_en  = 1'b1;
   logic [7:0] rd_byte = '0;
   logic prev_scl = 1'b1, prev_sda = 1'b1;
   int   bitcnt = 0, rd_idx = 0;
   logic ack_phase = 1'b0;
   logic [8:0] rxsh = '0;
   logic [8:0] cap [16];
   int   cap_n = 0, start_cnt = 0, stop_cnt = 0, scl_fall_cnt = 0;
   int   hi_cnt = 0, last_hi = 0, exit_cnt = 0;

   assign scl_line = !scl_drive_low;
   assign sda_line = !(sda_drive_low || pull);
   assign pull = rd_mode ? (rd_idx < 8 && !rd_byte[7 - (rd_idx % 8)])
                         : (ack_phase && ack_en);

   always #2.5 clk = ~clk;

   i2c_cmd_engine #(.CLK_HZ(4_000_000), .RESET_SPEED(3)) u0 (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_data(cmd_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
      .rsp_data(rsp_data), .exit_pulse(exit_pulse), .sda_in(sda_line),
      .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
      .pwr_en(pwr_en), .pullup_en(pullup_en), .aux_level(aux_level),
      .cs_level(cs_level)
   );

   always @(scl_line or sda_line) begin
      if (scl_line && prev_scl && sda_line != prev_sda) begin
         if (!sda_line) begin
            start_cnt++;
            bitcnt = 0; rd_idx = 0; ack_phase = 1'b0;
         end else begin
            stop_cnt++;
         end
      end else if (scl_line && !prev_scl) begin
         rxsh = {rxsh[7:0], sda_line};
         bitcnt++;
      end else if (!scl_line && prev_scl) begin
         scl_fall_cnt++;
         if (bitcnt == 9) begin
            if (cap_n < 16) cap[cap_n] = rxsh;
            cap_n++;
            bitcnt = 0;
            ack_phase = 1'b0;
         end else if (bitcnt == 8) begin
            ack_phase = 1'b1;
         end
         rd_idx = bitcnt;
      end
      prev_scl = scl_line;
      prev_sda = sda_line;
   end

   always @(negedge clk) begin
      if (exit_pulse) exit_cnt++;
      if (scl_line) hi_cnt++;
      else if (hi_cnt != 0) begin
         last_hi = hi_cnt;
         hi_cnt  = 0;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] b);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_data  = b;
      while (!cmd_ready) @(negedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic recv(output logic [7:0] b);
      while (!rsp_valid) @(negedge clk);
      b = rsp_data;
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
   endtask

   task automatic xfer(input logic [7:0] c, input logic [7:0] exp, input string req);
      logic [7:0] r;
      send(c);
      recv(r);
      chk(req, r, exp);
   endtask

   task automatic t_reset();
      chk("R12 reset rsp_valid", rsp_valid, 0);
      chk("R12 reset cmd_ready", cmd_ready, 1);
      chk("R8 reset pins", {pwr_en, pullup_en, aux_level, cs_level}, 0);
      chk("R10 reset bus released", {scl_drive_low, sda_drive_low}, 0);
   endtask

   task automatic t_ident();
      logic [7:0] r;
      send(8'h01);
      recv(r); chk("R5 byte0", r, 8'h49);
      recv(r); chk("R5 byte1", r, 8'h32);
      recv(r); chk("R5 byte2", r, 8'h43);
      recv(r); chk("R5 byte3", r, 8'h31);
   endtask

   task automatic t_start_ack();
      int s0 = start_cnt;
      xfer(8'h02, 8'h01, "R1 start reply");
      chk("R1 start seen", start_cnt - s0, 1);
      xfer(8'h06, 8'h01, "R4 ack reply");
      chk("R4 ack bit low", rxsh[0], 0);
      chk("R9 default high time", last_hi, 4);
   endtask

   task automatic t_bulk();
      logic [7:0] d [3] = '{8'hA5, 8'h03, 8'h3C};
      int p0 = stop_cnt;
      xfer(8'h02, 8'h01, "R1 start before bulk");
      cap_n  = 0;
      ack_en = 1'b1;
      xfer(8'h12, 8'h01, "R6 bulk header reply");
      for (int i = 0; i < 3; i++) xfer(d[i], 8'h00, "R6 slave ack reply");
      for (int i = 0; i < 3; i++) chk("R6 byte on bus", cap[i][8:1], d[i]);
      chk("R7 data 0x03 made no stop", stop_cnt - p0, 0);
      ack_en = 1'b0;
      xfer(8'h10, 8'h01, "R6 single header");
      xfer(8'h5A, 8'h01, "R6 slave nack reply");
      chk("R6 single byte on bus", cap[3][8:1], 8'h5A);
      ack_en = 1'b1;
      xfer(8'h05, 8'h00, "R7 decode resumes after bulk");
   endtask

   task automatic t_read();
      int p0;
      xfer(8'h02, 8'h01, "R1 start before read");
      rd_byte = 8'hC6;
      rd_mode = 1'b1;
      xfer(8'h04, 8'hC6, "R3 read byte");
      chk("R3 no ninth clock", bitcnt, 8);
      xfer(8'h07, 8'h01, "R4 nack reply");
      rd_mode = 1'b0;
      chk("R4 nack bit high", cap[cap_n - 1][0], 1);
      p0 = stop_cnt;
      xfer(8'h03, 8'h01, "R2 stop reply");
      chk("R2 stop seen", stop_cnt - p0, 1);
      chk("R2 bus idle", {scl_drive_low, sda_drive_low}, 0);
   endtask

   task automatic t_pins();
      xfer(8'h4A, 8'h01, "R8 pin reply");
      chk("R8 pins 0xA", {pwr_en, pullup_en, aux_level, cs_level}, 4'hA);
      xfer(8'h45, 8'h01, "R8 pin reply");
      chk("R8 pins 0x5", {pwr_en, pullup_en, aux_level, cs_level}, 4'h5);
   endtask

   task automatic t_speed();
      int hi [4] = '{400, 40, 20, 4};
      for (int c = 0; c < 4; c++) begin
         xfer(8'h60 + 8'(c), 8'h01, "R9 speed reply");
         xfer(8'h02, 8'h01, "R1 start");
         xfer(8'h06, 8'h01, "R4 ack");
         chk("R9 SCL high clocks", last_hi, hi[c]);
         xfer(8'h03, 8'h01, "R2 stop");
      end
   endtask

   task automatic t_unknown();
      int f0 = scl_fall_cnt;
      xfer(8'h05, 8'h00, "R10 unknown 0x05");
      xfer(8'h64, 8'h00, "R10 unknown 0x64");
      xfer(8'hFF, 8'h00, "R10 unknown 0xFF");
      chk("R10 no SCL activity", scl_fall_cnt - f0, 0);
      xfer(8'h06, 8'h01, "R10 speed kept");
      chk("R10 speed unchanged", last_hi, 4);
   endtask

   task automatic t_exit();
      int seen = 0;
      int e0 = exit_cnt;
      send(8'h00);
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (rsp_valid) seen = 1;
      end
      chk("R11 one exit strobe", exit_cnt - e0, 1);
      chk("R11 no reply", seen, 0);
   endtask

   task automatic t_hold();
      logic [7:0] d0, r;
      send(8'h4F);
      while (!rsp_valid) @(negedge clk);
      d0 = rsp_data;
      repeat (20) @(negedge clk);
      chk("R12 held valid", rsp_valid, 1);
      chk("R12 held data", rsp_data, d0);
      chk("R12 no cmd_ready", cmd_ready, 0);
      recv(r);
      chk("R12 value", r, 8'h01);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ident();
      t_start_ack();
      t_bulk();
      t_read();
      t_pins();
      t_speed();
      t_unknown();
      t_exit();
      t_hold();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule